// File: doc/BRIEF.md
# Polynomial coefficient carry reducer

This block normalises a polynomial whose coefficients are wide signed integers and whose base is z = 2^M + 857. After a polynomial multiply, each coefficient can be far wider than M bits. The block walks the coefficients upward from index 0, one per clock. At each index it takes the floor quotient q of the running value by 2^M and pushes q into the next coefficient. It then replaces the current coefficient with its non-negative low part r minus 857·q. Because 857·q·z^i plus q·z^(i+1) minus q·2^M·z^i cancels, the value Σ c_i·z^i does not change. The top coefficient only absorbs the final carry.

The carry step is cheap, so it runs one index per cycle. The 857·q correction lags behind in a three-addition shift-add pipeline, built on 857 = 32·(16+8) + 64 + (16+8) + 1, and writes each corrected coefficient back four cycles after its carry step. A whole polynomial arrives on a valid/ready input and leaves on a valid/ready output. Input is taken only while the block is idle. A finished result is held, unchanged, until the consumer takes it, and only then does the block accept new work. `in_ready` never depends on `in_valid`.

Top module: `ccr_carry_reducer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A transfer takes place on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the result has been handed over.
- R3: For the accepted input and the produced output, read as signed coefficients, Σ out_i·z^i equals Σ in_i·z^i, with z = 2^M + 857.
- R4: Coefficients are packed with coefficient i at bits [i·width +: width], signed two's complement: IN_W bits on input and IN_W+2 bits on output. For i = 0..NRED−1 in rising order, let c be the input coefficient plus the carry from index i−1. Then q = floor(c / 2^M), r = c − q·2^M (so 0 ≤ r < 2^M), out_i = r − 857·q, and q is carried into index i+1. The top coefficient out_NRED is in_NRED plus the last carry.
- R5: `out_valid` rises NRED+4 clock edges after the accepting edge (8 at the default parameters).
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_coef` does not change. The edge where both are 1 completes the handover. In the next cycle `out_valid` is 0 and `in_ready` is 1.
- R7: While the block is busy, `in_valid` has no effect. `in_ready` stays 0, the running job's result is unchanged, and no extra result is produced.
- R8: The boundary values follow R4. A running value of exactly 2^M leaves −857 and carries 1. A running value of −1 leaves 2^M − 1 + 857 and carries −1. Values in [0, 2^M) with no incoming carry pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input polynomial is present |
| in_ready | output | 1 | Block is idle and will take an input |
| in_coef | input | (NRED+1)·IN_W | Input coefficients, signed, index 0 in the low bits |
| out_valid | output | 1 | Reduced polynomial is present |
| out_ready | input | 1 | Consumer takes the result |
| out_coef | output | (NRED+1)·(IN_W+2) | Reduced coefficients, signed, index 0 in the low bits |

## Verification
The assertions assume that every input coefficient is a proper IN_W-bit signed value. They also assume IN_W exceeds M by enough headroom that 857 times the largest carry, and each carried-into coefficient, fit in IN_W+2 bits. Under those assumptions the shift-add product and the write-back schedule can be checked exactly. The stimulus stays inside that envelope by drawing every coefficient from the IN_W-bit range. That range includes its two extremes, all-ones, exact multiples of 2^M and random full-width patterns. The consumer holds `out_ready` low for stretches, and `in_valid` is pulsed while the block is busy, so the hold and ignore rules are tested against live results.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  // Small offset of the base z = 2^M + CORR_S
  localparam int unsigned CORR_S = 857;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_STEP,
    CS_DRAIN,
    CS_HOLD
  } ccr_state_e;
endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
#(
  parameter int unsigned NRED  = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             last_wb,
  output logic             in_ready,
  output logic             load,
  output logic             step_go,
  output logic [IDX_W-1:0] step_idx,
  output logic             out_valid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NRED - 1);

  ccr_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    in_ready  = (state_q == CS_IDLE);
    load      = in_valid && in_ready;
    step_go   = (state_q == CS_STEP);
    out_valid = (state_q == CS_HOLD);
    step_idx  = idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        CS_IDLE: begin
          if (load) begin
            state_q <= CS_STEP;
            idx_q   <= '0;
          end
        end
        CS_STEP: begin
          if (idx_q == LAST_IDX) state_q <= CS_DRAIN;
          else                   idx_q   <= idx_q + 1'b1;
        end
        CS_DRAIN: begin
          if (last_wb) state_q <= CS_HOLD;
        end
        CS_HOLD: begin
          if (out_ready) state_q <= CS_IDLE;
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccr_corr_pipe.sv
module ccr_corr_pipe #(
  parameter int unsigned W     = 138,
  parameter int unsigned IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic signed [W-1:0] in_q,
  input  logic [W-1:0]        in_r,
  output logic                wb_vld,
  output logic [IDX_W-1:0]    wb_idx,
  output logic signed [W-1:0] wb_val
);
  localparam int unsigned STAGES = 4;

  logic             vld_d [STAGES];
  logic [IDX_W-1:0] idx_d [STAGES];
  logic [W-1:0]     r_d   [STAGES];

  // Sideband delay line: valid, index and remainder follow the product
  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_side
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) vld_d[g] <= 1'b0;
        else        vld_d[g] <= in_vld;
        idx_d[g] <= in_idx;
        r_d[g]   <= in_r;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) vld_d[g] <= 1'b0;
        else        vld_d[g] <= vld_d[g-1];
        idx_d[g] <= idx_d[g-1];
        r_d[g]   <= r_d[g-1];
      end
    end
  end

  // 857q = 32*(16q + 8q) + 64q + (16q + 8q) + q, three addition cycles
  logic signed [W-1:0] q1, q2, t1, a_s, b_s, sq;

  always_ff @(posedge clk) begin
    q1  <= in_q;
    q2  <= q1;
    t1  <= (q1 <<< 4) + (q1 <<< 3);
    a_s <= (t1 <<< 5) + (q2 <<< 6);
    b_s <= t1 + q2;
    sq  <= a_s + b_s;
  end

  always_comb begin
    wb_vld = vld_d[STAGES-1];
    wb_idx = idx_d[STAGES-1];
    wb_val = $signed(r_d[STAGES-1]) - sq;
  end
endmodule

// File: rtl/ccr_coef_bank.sv
module ccr_coef_bank #(
  parameter int unsigned NCOEF = 5,
  parameter int unsigned IN_W  = 136,
  parameter int unsigned W     = 138,
  parameter int unsigned M     = 63,
  parameter int unsigned IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NCOEF*IN_W-1:0] in_coef,
  input  logic                  step_go,
  input  logic [IDX_W-1:0]      step_idx,
  input  logic                  wb_vld,
  input  logic [IDX_W-1:0]      wb_idx,
  input  logic signed [W-1:0]   wb_val,
  output logic signed [W-1:0]   split_q,
  output logic [W-1:0]          split_r,
  output logic [NCOEF*W-1:0]    out_coef
);
  logic signed [W-1:0] coef_all [NCOEF];
  logic signed [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NCOEF; k++) begin
      if (step_idx == IDX_W'(k)) sel = coef_all[k];
    end
    split_q = sel >>> M;
    split_r = {{(W-M){1'b0}}, sel[M-1:0]};
  end

  genvar i;
  for (i = 0; i < NCOEF; i++) begin : g_coef
    logic signed [W-1:0] val;
    logic [IN_W-1:0]     raw;

    assign raw = in_coef[i*IN_W +: IN_W];

    if (i == 0) begin : g_low
      always_ff @(posedge clk) begin
        if (!rst_n)                            val <= '0;
        else if (load)                         val <= {{(W-IN_W){raw[IN_W-1]}}, raw};
        else if (wb_vld && wb_idx == IDX_W'(i)) val <= wb_val;
      end
    end else begin : g_up
      always_ff @(posedge clk) begin
        if (!rst_n)                                     val <= '0;
        else if (load)                                  val <= {{(W-IN_W){raw[IN_W-1]}}, raw};
        else if (wb_vld && wb_idx == IDX_W'(i))          val <= wb_val;
        else if (step_go && step_idx == IDX_W'(i - 1))   val <= val + split_q;
      end
    end

    assign coef_all[i]          = val;
    assign out_coef[i*W +: W]   = val;
  end
endmodule

// File: rtl/ccr_carry_reducer.sv
module ccr_carry_reducer #(
  parameter int unsigned M    = 63,
  parameter int unsigned IN_W = 136,
  parameter int unsigned NRED = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [(NRED+1)*IN_W-1:0]       in_coef,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [(NRED+1)*(IN_W+2)-1:0]   out_coef
);
  localparam int unsigned NCOEF = NRED + 1;
  localparam int unsigned W     = IN_W + 2;
  localparam int unsigned IDX_W = (NCOEF > 1) ? $clog2(NCOEF) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NRED - 1);

  logic                load, step_go, wb_vld, last_wb;
  logic [IDX_W-1:0]    step_idx, wb_idx;
  logic signed [W-1:0] split_q, wb_val;
  logic [W-1:0]        split_r;

  assign last_wb = wb_vld && (wb_idx == LAST_IDX);

  ccr_ctrl #(.NRED(NRED), .IDX_W(IDX_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .last_wb   (last_wb),
    .in_ready  (in_ready),
    .load      (load),
    .step_go   (step_go),
    .step_idx  (step_idx),
    .out_valid (out_valid)
  );

  ccr_coef_bank #(.NCOEF(NCOEF), .IN_W(IN_W), .W(W), .M(M), .IDX_W(IDX_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .in_coef  (in_coef),
    .step_go  (step_go),
    .step_idx (step_idx),
    .wb_vld   (wb_vld),
    .wb_idx   (wb_idx),
    .wb_val   (wb_val),
    .split_q  (split_q),
    .split_r  (split_r),
    .out_coef (out_coef)
  );

  ccr_corr_pipe #(.W(W), .IDX_W(IDX_W)) i_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (step_go),
    .in_idx (step_idx),
    .in_q   (split_q),
    .in_r   (split_r),
    .wb_vld (wb_vld),
    .wb_idx (wb_idx),
    .wb_val (wb_val)
  );
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int unsigned M    = 63,
  parameter int unsigned IN_W = 136,
  parameter int unsigned NRED = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [(NRED+1)*(IN_W+2)-1:0] out_coef,
  input logic                         step_go,
  input logic [((NRED+1) > 1 ? $clog2(NRED+1) : 1)-1:0] step_idx,
  input logic                         wb_vld,
  input logic [((NRED+1) > 1 ? $clog2(NRED+1) : 1)-1:0] wb_idx,
  input logic signed [IN_W+1:0]       wb_val,
  input logic signed [IN_W+1:0]       split_q,
  input logic [IN_W+1:0]              split_r
);
  localparam int unsigned W = IN_W + 2;
  localparam logic signed [W-1:0] SC = W'(857);

  // Cycles since acceptance; equals NRED+5 on the sample where out_valid rises,
  // i.e. out_valid was set NRED+4 edges after the accepting edge.
  int unsigned lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                        lat_cnt <= 0;
    else if (in_valid && in_ready)     lat_cnt <= 1;
    else if (out_valid && out_ready)   lat_cnt <= 0;
    else if (lat_cnt != 0 && !out_valid) lat_cnt <= lat_cnt + 1;
  end

  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_correction_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> (wb_val == ($signed($past(split_r, 4)) - SC * $past(split_q, 4))));

  assert_no_write_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && wb_vld) |-> (wb_idx != step_idx + 1'b1));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == NRED + 5));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !(out_valid && out_ready)) |=> !in_ready);
endmodule

bind ccr_carry_reducer ccr_checker #(.M(M), .IN_W(IN_W), .NRED(NRED)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coef  (out_coef),
  .step_go   (step_go),
  .step_idx  (step_idx),
  .wb_vld    (wb_vld),
  .wb_idx    (wb_idx),
  .wb_val    (wb_val),
  .split_q   (split_q),
  .split_r   (split_r)
);

// File: tb/test_ccr_carry_reducer.sv
`timescale 1ns/1ps
module test_ccr_carry_reducer;
  localparam int M     = 63;
  localparam int IN_W  = 136;
  localparam int NRED  = 4;
  localparam int NCOEF = NRED + 1;
  localparam int W     = IN_W + 2;
  localparam int LAT   = NRED + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [NCOEF*IN_W-1:0] in_coef = '0;
  logic in_ready, out_valid;
  logic [NCOEF*W-1:0] out_coef;

  always #2.5 clk = ~clk;

  ccr_carry_reducer #(.M(M), .IN_W(IN_W), .NRED(NRED)) i_ccr_carry_reducer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef)
  );

  typedef struct {
    logic [NCOEF*W-1:0] coefs;
    logic signed [511:0] vin;
    int    stall;
    int    acc;
    string req;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NCOEF*W-1:0] widen(input logic [NCOEF*IN_W-1:0] v);
    logic [NCOEF*W-1:0] o;
    o = '0;
    for (int i = 0; i < NCOEF; i++)
      o[i*W +: W] = {{(W-IN_W){v[i*IN_W+IN_W-1]}}, v[i*IN_W +: IN_W]};
    return o;
  endfunction

  // Expected result from R4: floor quotient, non-negative remainder
  function automatic logic [NCOEF*W-1:0] model(input logic [NCOEF*IN_W-1:0] v);
    logic [NCOEF*W-1:0] wv, o;
    logic signed [W-1:0] c [NCOEF];
    logic signed [W-1:0] q, r, s;
    wv = widen(v);
    s = W'(857);
    for (int i = 0; i < NCOEF; i++) c[i] = wv[i*W +: W];
    for (int i = 0; i < NRED; i++) begin
      q = c[i] >>> M;
      r = c[i] - (q <<< M);
      c[i+1] = c[i+1] + q;
      c[i] = r - s * q;
    end
    o = '0;
    for (int i = 0; i < NCOEF; i++) o[i*W +: W] = c[i];
    return o;
  endfunction

  // Polynomial value at z = 2^M + 857 (R3)
  function automatic logic signed [511:0] value_of(input logic [NCOEF*W-1:0] o);
    logic signed [511:0] acc, z, t;
    z = (512'sd1 <<< M) + 512'sd857;
    acc = '0;
    for (int i = NCOEF - 1; i >= 0; i--) begin
      t = {{(512-W){o[i*W+W-1]}}, o[i*W +: W]};
      acc = acc * z + t;
    end
    return acc;
  endfunction

  function automatic logic [NCOEF*IN_W-1:0] all_same(input logic [IN_W-1:0] x);
    logic [NCOEF*IN_W-1:0] v;
    for (int i = 0; i < NCOEF; i++) v[i*IN_W +: IN_W] = x;
    return v;
  endfunction

  task automatic send(input logic [NCOEF*IN_W-1:0] v, input int stall, input string req);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_coef  = v;
    e.coefs = model(v);
    e.vin   = value_of(widen(v));
    e.stall = stall;
    e.acc   = cyc + 1;
    e.req   = req;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2", "in_ready after accept", in_ready, 0);
  endtask

  // in_valid while busy (R7)
  task automatic poke(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7", "in_ready while busy", in_ready, 0);
      in_valid = 1'b1;
      in_coef  = all_same({IN_W{1'b1}} >> 3);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin : monitor
    bit prev_ov;
    bit post_hs;
    int stall_left;
    logic [NCOEF*W-1:0] snap;
    exp_t e;
    prev_ov = 0; post_hs = 0; stall_left = 0; snap = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (post_hs) begin
        chk(out_valid == 1'b0, "R6", "out_valid after handover", out_valid, 0);
        chk(in_ready == 1'b1, "R6", "in_ready after handover", in_ready, 1);
        post_hs = 0;
      end
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7", "result without accepted input", out_coef, 0);
          out_ready = 1'b1;
        end else begin
          if (!prev_ov) begin
            chk(cyc - sb[0].acc == LAT, "R5", "latency", cyc - sb[0].acc, LAT);
            stall_left = sb[0].stall;
            snap = out_coef;
          end else begin
            chk(out_coef == snap, "R6", "out_coef held", out_coef, snap);
            chk(in_ready == 1'b0, "R2", "in_ready while holding", in_ready, 0);
          end
          if (stall_left > 0) begin
            out_ready = 1'b0;
            stall_left--;
          end else begin
            out_ready = 1'b1;
            e = sb.pop_front();
            for (int i = 0; i < NCOEF; i++)
              chk(out_coef[i*W +: W] == e.coefs[i*W +: W], e.req,
                  $sformatf("coefficient %0d", i), out_coef[i*W +: W], e.coefs[i*W +: W]);
            chk(value_of(out_coef) == e.vin, "R3", "polynomial value",
                value_of(out_coef), e.vin);
            post_hs = 1;
          end
        end
      end else begin
        out_ready = 1'b0;
      end
      prev_ov = out_valid;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [NCOEF*IN_W-1:0] v;
    logic [IN_W-1:0] zm;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    send('0, 0, "R4");

    // R8: small values pass through unchanged
    v = '0;
    for (int i = 0; i < NCOEF; i++) v[i*IN_W +: IN_W] = IN_W'(i + 1);
    send(v, 0, "R8");

    // R8: exactly 2^M at index 0
    zm = '0; zm[M] = 1'b1;
    v = '0; v[0 +: IN_W] = zm;
    send(v, 2, "R8");

    // R8: all -1
    send(all_same({IN_W{1'b1}}), 0, "R8");

    // extremes
    send(all_same({1'b0, {(IN_W-1){1'b1}}}), 3, "R4");
    send(all_same({1'b1, {(IN_W-1){1'b0}}}), 0, "R4");

    // alternating signs
    v = '0;
    for (int i = 0; i < NCOEF; i++)
      v[i*IN_W +: IN_W] = (i % 2 == 0) ? {2'b01, {(IN_W-2){1'b1}}} : {2'b10, {(IN_W-2){1'b0}}};
    send(v, 1, "R4");

    // R7: in_valid pulses while a stalled job is in flight
    send(all_same(IN_W'(136'h123456789abcdef0fedcba9876543210)), 12, "R7");
    poke(3);

    // random full-width patterns, some back-to-back, some stalled
    for (int n = 0; n < 10; n++) begin
      v = '0;
      for (int k = 0; k < (NCOEF*IN_W + 31) / 32; k++) v = (v << 32) | NCOEF*IN_W'($urandom);
      send(v, n % 3, "R4");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule